// File: doc/BRIEF.md
# Calendar Clock Core with Banked Battery RAM

This block keeps the time of day and the date for a host processor. It counts seconds, minutes, hours, day of week, date, month and a two-digit year over a century. Months have their true lengths, and February gains a 29th day in every year divisible by four. The time base is a 32.768 kHz enable pulse. A prescaler turns it into one calendar step per second and into a periodic interrupt whose rate is programmable. Three interrupt sources are provided: an alarm match, the periodic rate, and the end of each once-per-second update. Each source has its own enable, and together they drive a single request line.

The host sees a byte-wide index/data port. It first writes an index, then reads or writes the data byte at that index. The index space holds the seven time fields, three alarm bytes, a rate byte, a mode byte, a flag byte and a lock byte. The remaining 242 indexes are general-purpose RAM in two banks, and each bank can be locked on its own. The host sets the time inside a freeze window. While the freeze bit is set, field writes collect in a holding copy. When the bit is cleared, all fields move into the running counters in one clock, so a partly written time never runs.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the counters hold 00:00:00, day of week 1, date 1, month 1, year 0. The mode byte (index 11) reads 0x02, which selects 24-hour BCD with all interrupt enables off. The flag byte reads 0x00 and irq is low.
- R2: One second elapses every 2^DIV_BITS enabled ticks. Each field carries into the next one. Day of week runs 1..7 and wraps to 1. Year 99 is followed by year 00, month 1, date 1.
- R3: A month has 28, 30 or 31 days as it should. February has 29 days when the year field is divisible by 4.
- R4: When mode bit 2 is 1, the time and alarm fields are written and read as plain binary. When it is 0 they use two-digit packed BCD.
- R5: When mode bit 1 is 0, the hour byte uses 12-hour form: values 1..12, with bit 7 set for PM. Midnight reads 0x12, and noon reads 0x92 in BCD.
- R6: With mode bit 0 set, daylight saving applies on a Sunday (day of week 1). In April, on dates 1..7, 01:59:59 steps to 03:00:00. In October, on dates 25..31, 01:59:59 steps back to 01:00:00, and this happens once.
- R7: The alarm bytes are at index 7 (seconds), 8 (minutes) and 9 (hours). Each one matches when it equals the encoded current value, or when its bits 7:6 are both 1. The alarm flag is set after a second update where all three match.
- R8: The flag byte (index 12) holds bit 6 periodic, bit 5 alarm, bit 4 update-ended, and bit 7 equal to irq. irq is the OR of each flag ANDed with its enable, mode bits 6/5/4. A flag sets even when its enable is off. Reading the flag byte clears all flags.
- R9: A rate value r from 3 to 15 (index 10, bits 3:0) sets the periodic flag every 2^(r-1) ticks. Values 0 to 2 never set it.
- R10: Indexes 14..127 form RAM bank 0 and indexes 128..255 form bank 1. Each byte keeps its value, and reset does not clear the contents.
- R11: Writing a 1 to bit 0 or bit 1 of the lock byte (index 13) locks bank 0 or bank 1. A locked bank ignores writes and reads as 0xFF. A lock can only be removed by reset.
- R12: Setting mode bit 7 freezes the counters and the prescaler, and time-field reads then return the holding copy. Clearing the bit loads the holding copy at once and restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz time-base rate |
| idx_wr | input | 1 | Load bus_wdata into the index register |
| dat_wr | input | 1 | Write bus_wdata to the indexed location |
| dat_rd | input | 1 | Read strobe for the indexed location; clears flags at index 12 |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Indexed data, combinational from the index register |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses DIV_BITS = 6, and tick_en is high on every cycle. When the freeze bit is cleared at edge E, the counters load at E+1, the next second lands at E+64, and the update-ended and alarm flags follow one cycle later at E+65. The bench therefore waits 70 cycles after release and finishes all its field reads before E+128. Read data is sampled one time unit after the strobe is driven at a falling edge, and flag clears take effect at the next rising edge. Periodic rates are measured as the cycle distance between two irq assertions, with a flag-clearing read between them.

// File: rtl/rtc_pkg.sv
// Shared types, index map and format helpers for the calendar clock core.
// Assumes an 8-bit index space; the time fields are held internally in binary.
package rtc_pkg;
    localparam int IDX_W = 8;
    localparam logic [7:0] IX_SEC    = 8'd0;
    localparam logic [7:0] IX_MIN    = 8'd1;
    localparam logic [7:0] IX_HOUR   = 8'd2;
    localparam logic [7:0] IX_DOW    = 8'd3;
    localparam logic [7:0] IX_DATE   = 8'd4;
    localparam logic [7:0] IX_MONTH  = 8'd5;
    localparam logic [7:0] IX_YEAR   = 8'd6;
    localparam logic [7:0] IX_AL_SEC = 8'd7;
    localparam logic [7:0] IX_AL_MIN = 8'd8;
    localparam logic [7:0] IX_AL_HR  = 8'd9;
    localparam logic [7:0] IX_RATE   = 8'd10;
    localparam logic [7:0] IX_MODE   = 8'd11;
    localparam logic [7:0] IX_FLAGS  = 8'd12;
    localparam logic [7:0] IX_LOCK   = 8'd13;
    localparam int RAM_BASE  = 14;
    localparam int RAM_SPLIT = 128;
    localparam int RAM_TOP   = 256;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 7'd0, month: 4'd1, date: 5'd1,
                                   dow: 3'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

    // Binary 0..99 to packed BCD.
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Packed BCD to binary.
    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    // Length of a month; every fourth year is a leap year.
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        logic [4:0] n;
        case (m)
            4'd2:                     n = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  n = 5'd30;
            default:                  n = 5'd31;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/rtc_timebase.sv
// Prescaler for the calendar clock core.
// Counts tick_en pulses and produces a one-second step and a periodic pulse.
// Assumes tick_en is a single-cycle pulse. While hold is high the prescaler is cleared.
module rtc_timebase #(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       hold,
    input  logic [3:0] rate,
    output logic       sec_pulse,
    output logic       per_pulse
);
    logic [DIV_BITS-1:0] presc;
    logic [DIV_BITS-1:0] mask;
    logic [4:0]          shamt;
    logic                sec_hit;
    logic                per_hit;

    assign shamt   = 5'(rate) - 5'd1;
    assign sec_hit = &presc;

    // Prescaler counts enabled ticks and is cleared while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) presc <= '0;
        else if (tick_en)   presc <= presc + 1'b1;
    end

    // Periodic match: the low (rate-1) prescaler bits are all ones.
    always_comb begin
        mask    = '0;
        per_hit = 1'b0;
        if (rate >= 4'd3) begin
            if (int'(shamt) >= DIV_BITS) begin
                per_hit = sec_hit;
            end else begin
                mask    = DIV_BITS'((32'd1 << shamt) - 32'd1);
                per_hit = ((presc & mask) == mask);
            end
        end
    end

    assign sec_pulse = tick_en && !hold && sec_hit;
    assign per_pulse = tick_en && !hold && per_hit;

    assert_hold_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (presc == '0));
endmodule

// File: rtl/rtc_calendar.sv
// Calendar counter with a holding copy for atomic time setting.
// Steps sec..year once per step pulse, applies daylight saving, and loads the
// holding copy when the freeze bit falls. All fields are binary.
module rtc_calendar (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              set_mode,
    input  logic              dse_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_field,
    input  logic [6:0]        wr_val,
    output rtc_pkg::cal_t     live_o,
    output rtc_pkg::cal_t     view_o
);
    import rtc_pkg::*;

    cal_t live, hold, nxt;
    logic set_q, fell_back, fb_set, load, grab;

    assign load = set_q && !set_mode;
    assign grab = set_mode && !set_q;

    // Next-second value with carries, daylight saving and the leap rule.
    always_comb begin
        nxt    = live;
        fb_set = 1'b0;
        if (live.sec != 6'd59) begin
            nxt.sec = live.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (live.min != 6'd59) begin
                nxt.min = live.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (dse_en && live.dow == 3'd1 && live.hour == 5'd1 &&
                    live.month == 4'd4 && live.date <= 5'd7) begin
                    nxt.hour = 5'd3;
                end else if (dse_en && live.dow == 3'd1 && live.hour == 5'd1 &&
                             live.month == 4'd10 && live.date >= 5'd25 && !fell_back) begin
                    nxt.hour = 5'd1;
                    fb_set   = 1'b1;
                end else if (live.hour != 5'd23) begin
                    nxt.hour = live.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.dow  = (live.dow == 3'd7) ? 3'd1 : live.dow + 3'd1;
                    if (live.date < month_len(live.month, live.year)) begin
                        nxt.date = live.date + 5'd1;
                    end else begin
                        nxt.date = 5'd1;
                        if (live.month < 4'd12) begin
                            nxt.month = live.month + 4'd1;
                        end else begin
                            nxt.month = 4'd1;
                            nxt.year  = (live.year >= 7'd99) ? 7'd0 : live.year + 7'd1;
                        end
                    end
                end
            end
        end
    end

    // Holding copy: snapshot on freeze entry, then host field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= CAL_RESET;
            set_q <= 1'b0;
        end else begin
            set_q <= set_mode;
            if (grab) begin
                hold <= live;
            end else if (wr_en) begin
                case (wr_field)
                    3'd0:    hold.sec   <= wr_val[5:0];
                    3'd1:    hold.min   <= wr_val[5:0];
                    3'd2:    hold.hour  <= wr_val[4:0];
                    3'd3:    hold.dow   <= wr_val[2:0];
                    3'd4:    hold.date  <= wr_val[4:0];
                    3'd5:    hold.month <= wr_val[3:0];
                    default: hold.year  <= wr_val;
                endcase
            end
        end
    end

    // Running counters: load on freeze exit, otherwise advance once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= CAL_RESET;
            fell_back <= 1'b0;
        end else if (load) begin
            live      <= hold;
            fell_back <= 1'b0;
        end else if (step) begin
            live <= nxt;
            if (fb_set)                fell_back <= 1'b1;
            else if (nxt.hour != 5'd1) fell_back <= 1'b0;
        end
    end

    assign live_o = live;
    assign view_o = set_mode ? hold : live;

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && live.sec == 6'd59) |=> (live.sec == 6'd0));
    assert_date_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && live.date >= 5'd1 && live.date <= month_len(live.month, live.year))
        |=> (live.date >= 5'd1 && live.date <= month_len(live.month, live.year)));
    assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> $stable(live));
endmodule

// File: rtl/rtc_nvram.sv
// Two-bank general-purpose RAM behind the index port, with sticky per-bank locks.
// Assumes the contents survive reset; only the lock bits are reset.
module rtc_nvram #(
    parameter int BASE  = 14,
    parameter int SPLIT = 128,
    parameter int TOP   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic [1:0] lock_set,
    output logic [7:0] rdata,
    output logic [1:0] lock_o
);
    localparam int DEPTH = TOP - BASE;

    logic [7:0] mem [DEPTH];
    logic [1:0] lock_q;
    logic [7:0] off;
    logic       in_range, upper, blocked;

    assign in_range = (addr >= 8'(BASE));
    assign upper    = (addr >= 8'(SPLIT));
    assign blocked  = upper ? lock_q[1] : lock_q[0];
    assign off      = addr - 8'(BASE);

    // Lock bits only ever set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 2'b00;
        else        lock_q <= lock_q | lock_set;
    end

    // Storage write, suppressed for a locked bank.
    always_ff @(posedge clk) begin
        if (we && in_range && !blocked) mem[off] <= wdata;
    end

    assign rdata  = (!in_range || blocked) ? 8'hFF : mem[off];
    assign lock_o = lock_q;

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(lock_q[0]) && !$fell(lock_q[1]));
endmodule

// File: rtl/rtc_calendar_core.sv
// Top of the calendar clock core: index/data host port, format conversion,
// alarm compare, interrupt flags and the RAM window.
// Assumes one host strobe per cycle. Read data is combinational from the index register.
module rtc_calendar_core #(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    import rtc_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic [7:0] al_sec, al_min, al_hr, mode_q;
    logic [3:0] rate_q;
    logic [2:0] flags_q, flag_set, flag_en;
    logic       step_d, sec_pulse, per_pulse, rd_flags, alarm_hit;
    logic       bin, h24;
    logic [6:0] wr_val;
    logic [7:0] ram_rdata, enc_sec, enc_min, enc_hr;
    logic [1:0] lock_bits, lock_set;
    cal_t       live, view;

    assign bin     = mode_q[2];
    assign h24     = mode_q[1];
    assign flag_en = mode_q[6:4];

    function automatic logic [7:0] enc7(input logic [6:0] v, input logic b);
        return b ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [6:0] dec7(input logic [7:0] v, input logic b);
        return b ? v[6:0] : from_bcd(v);
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic b, input logic t24);
        logic [6:0] v;
        logic [7:0] r;
        logic       pm;
        v  = 7'(h);
        pm = 1'b0;
        if (!t24) begin
            pm = (h >= 5'd12);
            if (h == 5'd0)       v = 7'd12;
            else if (h > 5'd12)  v = 7'(h - 5'd12);
        end
        r    = enc7(v, b);
        r[7] = pm;
        return r;
    endfunction

    function automatic logic [6:0] dec_hour(input logic [7:0] x, input logic b, input logic t24);
        logic [6:0] raw;
        raw = dec7({1'b0, x[6:0]}, b);
        if (!t24) begin
            if (raw == 7'd12) raw = x[7] ? 7'd12 : 7'd0;
            else if (x[7])    raw = raw + 7'd12;
        end
        return raw;
    endfunction

    rtc_timebase #(.DIV_BITS(DIV_BITS)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold(mode_q[7]),
        .rate(rate_q), .sec_pulse(sec_pulse), .per_pulse(per_pulse)
    );

    assign wr_val = (idx_q == IX_HOUR) ? dec_hour(bus_wdata, bin, h24) : dec7(bus_wdata, bin);

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .step(sec_pulse), .set_mode(mode_q[7]),
        .dse_en(mode_q[0]), .wr_en(dat_wr && idx_q <= IX_YEAR),
        .wr_field(idx_q[2:0]), .wr_val(wr_val), .live_o(live), .view_o(view)
    );

    assign lock_set = (dat_wr && idx_q == IX_LOCK) ? bus_wdata[1:0] : 2'b00;

    rtc_nvram #(.BASE(RAM_BASE), .SPLIT(RAM_SPLIT), .TOP(RAM_TOP)) u_ram (
        .clk(clk), .rst_n(rst_n), .addr(idx_q),
        .we(dat_wr && idx_q >= 8'(RAM_BASE)), .wdata(bus_wdata),
        .lock_set(lock_set), .rdata(ram_rdata), .lock_o(lock_bits)
    );

    // Alarm compare on the encoded current time, bits 7:6 = 11 is a wildcard.
    assign enc_sec   = enc7(7'(live.sec), bin);
    assign enc_min   = enc7(7'(live.min), bin);
    assign enc_hr    = enc_hour(live.hour, bin, h24);
    assign alarm_hit = (al_sec[7:6] == 2'b11 || al_sec == enc_sec) &&
                       (al_min[7:6] == 2'b11 || al_min == enc_min) &&
                       (al_hr[7:6]  == 2'b11 || al_hr  == enc_hr);

    assign rd_flags = dat_rd && (idx_q == IX_FLAGS);
    assign flag_set = {per_pulse, step_d && alarm_hit, step_d};
    assign irq      = |(flags_q & flag_en);

    // Host-visible control registers and the index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            al_sec <= 8'h00;
            al_min <= 8'h00;
            al_hr  <= 8'h00;
            rate_q <= 4'd0;
            mode_q <= 8'h02;
        end else begin
            if (idx_wr) idx_q <= bus_wdata;
            if (dat_wr) begin
                case (idx_q)
                    IX_AL_SEC: al_sec <= bus_wdata;
                    IX_AL_MIN: al_min <= bus_wdata;
                    IX_AL_HR:  al_hr  <= bus_wdata;
                    IX_RATE:   rate_q <= bus_wdata[3:0];
                    IX_MODE:   mode_q <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // Event flags: a new event wins over a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 3'b000;
            step_d  <= 1'b0;
        end else begin
            step_d  <= sec_pulse;
            flags_q <= (rd_flags ? 3'b000 : flags_q) | flag_set;
        end
    end

    // Read multiplexer on the index register.
    always_comb begin
        case (idx_q)
            IX_SEC:    bus_rdata = enc7(7'(view.sec), bin);
            IX_MIN:    bus_rdata = enc7(7'(view.min), bin);
            IX_HOUR:   bus_rdata = enc_hour(view.hour, bin, h24);
            IX_DOW:    bus_rdata = enc7(7'(view.dow), bin);
            IX_DATE:   bus_rdata = enc7(7'(view.date), bin);
            IX_MONTH:  bus_rdata = enc7(7'(view.month), bin);
            IX_YEAR:   bus_rdata = enc7(view.year, bin);
            IX_AL_SEC: bus_rdata = al_sec;
            IX_AL_MIN: bus_rdata = al_min;
            IX_AL_HR:  bus_rdata = al_hr;
            IX_RATE:   bus_rdata = {4'b0000, rate_q};
            IX_MODE:   bus_rdata = mode_q;
            IX_FLAGS:  bus_rdata = {irq, flags_q, 4'b0000};
            IX_LOCK:   bus_rdata = {6'b000000, lock_bits};
            default:   bus_rdata = ram_rdata;
        endcase
    end

    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && flag_set == 3'b000) |=> (flags_q == 3'b000));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_flags && flags_q[1]) |=> flags_q[1]);
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr && idx_q == IX_MODE) |=> $stable(mode_q));
endmodule

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/100ps
module rtc_calendar_core_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq;
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_calendar_core #(.DIV_BITS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idx_wr(idx_wr),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); idx_wr = 1'b1; bus_wdata = idx;
        @(negedge clk); idx_wr = 1'b0; dat_wr = 1'b1; bus_wdata = val;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] val);
        @(negedge clk); idx_wr = 1'b1; bus_wdata = idx;
        @(negedge clk); idx_wr = 1'b0; dat_rd = 1'b1;
        #1 val = bus_rdata;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic set_time(input logic [7:0] mode, input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(8'd11, mode | 8'h80);
        wr(8'd0, s); wr(8'd1, m); wr(8'd2, h); wr(8'd3, dw);
        wr(8'd4, dt); wr(8'd5, mo); wr(8'd6, yr);
        wr(8'd11, mode);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int t);
        t = -1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq) begin t = cyc; break; end
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 sec", 8'd0, 8'h00);
        rd_chk("R1 dow", 8'd3, 8'h01);
        rd_chk("R1 date", 8'd4, 8'h01);
        rd_chk("R1 month", 8'd5, 8'h01);
        rd_chk("R1 mode", 8'd11, 8'h02);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd_chk("R1 flags", 8'd12, 8'h00);
    endtask

    task automatic t_century;
        set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        wait_cycles(70);
        rd_chk("R2 sec", 8'd0, 8'h00);
        rd_chk("R2 hour", 8'd2, 8'h00);
        rd_chk("R2 dow wrap", 8'd3, 8'h01);
        rd_chk("R2 date", 8'd4, 8'h01);
        rd_chk("R2 month", 8'd5, 8'h01);
        rd_chk("R2 year wrap", 8'd6, 8'h00);
    endtask

    task automatic t_leap;
        set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        wait_cycles(70);
        rd_chk("R3 leap date", 8'd4, 8'h29);
        rd_chk("R3 leap month", 8'd5, 8'h02);
        set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        wait_cycles(70);
        rd_chk("R3 common date", 8'd4, 8'h01);
        rd_chk("R3 common month", 8'd5, 8'h03);
        set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
        wait_cycles(70);
        rd_chk("R3 30-day month", 8'd5, 8'h05);
    endtask

    task automatic t_binary;
        set_time(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd31, 8'd1, 8'd99);
        wait_cycles(70);
        rd_chk("R4 bin sec", 8'd0, 8'h00);
        rd_chk("R4 bin hour", 8'd2, 8'h00);
        rd_chk("R4 bin dow", 8'd3, 8'h04);
        rd_chk("R4 bin date", 8'd4, 8'h01);
        rd_chk("R4 bin month", 8'd5, 8'h02);
        rd_chk("R4 bin year", 8'd6, 8'd99);
    endtask

    task automatic t_12h;
        set_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h03, 8'h24);
        wait_cycles(70);
        rd_chk("R5 noon", 8'd2, 8'h92);
        set_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h03, 8'h24);
        wait_cycles(70);
        rd_chk("R5 1pm", 8'd2, 8'h81);
        set_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h03, 8'h24);
        wait_cycles(70);
        rd_chk("R5 midnight", 8'd2, 8'h12);
        rd_chk("R5 midnight date", 8'd4, 8'h11);
    endtask

    task automatic t_dst;
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04, 8'h24);
        wait_cycles(70);
        rd_chk("R6 spring fwd", 8'd2, 8'h03);
        set_time(8'h03, 8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h24);
        wait_cycles(70);
        rd_chk("R6 fall back hour", 8'd2, 8'h01);
        rd_chk("R6 fall back min", 8'd1, 8'h00);
        set_time(8'h02, 8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04, 8'h24);
        wait_cycles(70);
        rd_chk("R6 disabled", 8'd2, 8'h02);
    endtask

    task automatic t_alarm;
        logic [7:0] v;
        wr(8'd7, 8'h05); wr(8'd8, 8'hC0); wr(8'd9, 8'hC0);
        set_time(8'h22, 8'h04, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24);
        rd(8'd12, v);
        wait_cycles(70);
        chk("R7 alarm irq", {7'd0, irq}, 8'h01);
        rd_chk("R7 alarm flags", 8'd12, 8'hB0);
        chk("R8 irq after read", {7'd0, irq}, 8'h00);
        rd_chk("R8 read cleared", 8'd12, 8'h00);
        set_time(8'h02, 8'h04, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24);
        rd(8'd12, v);
        wait_cycles(70);
        chk("R8 masked irq", {7'd0, irq}, 8'h00);
        rd_chk("R8 masked flags", 8'd12, 8'h30);
        wr(8'd9, 8'h07);
        set_time(8'h22, 8'h04, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24);
        rd(8'd12, v);
        wait_cycles(70);
        chk("R7 hour mismatch irq", {7'd0, irq}, 8'h00);
        rd_chk("R7 hour mismatch flags", 8'd12, 8'h10);
        set_time(8'h12, 8'h04, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24);
        rd(8'd12, v);
        wait_cycles(70);
        chk("R8 update irq", {7'd0, irq}, 8'h01);
        rd(8'd12, v);
    endtask

    task automatic rate_period(input logic [3:0] r, output int p);
        logic [7:0] v;
        int t0, t1;
        wr(8'd10, {4'd0, r});
        set_time(8'h42, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24);
        rd(8'd12, v);
        wait_irq(t0);
        rd(8'd12, v);
        wait_irq(t1);
        p = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
    endtask

    task automatic t_periodic;
        logic [7:0] v;
        int p, t;
        rate_period(4'd3, p);
        chk("R9 rate 3 period", 8'(p), 8'd4);
        rate_period(4'd5, p);
        chk("R9 rate 5 period", 8'(p), 8'd16);
        wr(8'd10, 8'd0);
        rd(8'd12, v);
        wait_irq(t);
        chk("R9 rate 0 silent", {7'd0, t >= 0}, 8'h00);
        wr(8'd11, 8'h02);
    endtask

    task automatic t_ram;
        wr(8'd20, 8'h5A);
        wr(8'd200, 8'hA5);
        rd_chk("R10 bank0", 8'd20, 8'h5A);
        rd_chk("R10 bank1", 8'd200, 8'hA5);
        wr(8'd13, 8'h01);
        wr(8'd20, 8'h00);
        rd_chk("R11 locked read", 8'd20, 8'hFF);
        rd_chk("R11 other bank open", 8'd200, 8'hA5);
        wr(8'd13, 8'h00);
        rd_chk("R11 lock sticky", 8'd13, 8'h01);
        wr(8'd13, 8'h02);
        rd_chk("R11 bank1 locked", 8'd200, 8'hFF);
    endtask

    task automatic t_freeze;
        logic [7:0] v;
        wr(8'd11, 8'h82);
        wr(8'd0, 8'h30);
        rd_chk("R12 hold view", 8'd0, 8'h30);
        wait_cycles(150);
        rd_chk("R12 frozen", 8'd0, 8'h30);
        wr(8'd11, 8'h02);
        wait_cycles(10);
        rd_chk("R12 loaded", 8'd0, 8'h30);
        wait_cycles(60);
        rd_chk("R12 restart", 8'd0, 8'h31);
        rd(8'd12, v);
    endtask

    task automatic t_after_reset;
        @(negedge clk); rst_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        rd_chk("R10 survives reset", 8'd20, 8'h5A);
        rd_chk("R11 locks cleared", 8'd13, 8'h00);
        rd_chk("R1 mode after reset", 8'd11, 8'h02);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        tick_en = 1'b1;
        t_reset();
        t_century();
        t_leap();
        t_binary();
        t_12h();
        t_dst();
        t_alarm();
        t_periodic();
        t_freeze();
        t_ram();
        t_after_reset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule